// File: doc/BRIEF.md
# Tri-state OOK remote code word decoder

This block takes the demodulated, already-sampled data line of an on-off keyed remote-control receiver and recovers the tri-state code words that it carries. Every transition of the line is time-stamped by a free-running width counter. The decoder first hunts for the synchronisation pulse: a short high level followed by a low level about thirty times longer. Once locked, it reads the symbols of one word. Each symbol is a group of four consecutive level widths, and the decoder classifies them as two short/long pairs.

A word holds `N_ADDR` address positions, each one '0', '1' or 'F', followed by `N_DATA` data bits. A word counts as complete only when a fresh sync pulse follows its last symbol. The decoder compares each completed word with the one before it, and reports a word only when two consecutive decodes agree. Transmitters send the same word several times, and the receiver often loses the start of a burst. The decoder therefore always locks on a later repetition. While the line keeps toggling, it suppresses repeated reports of the word it has just reported.

Top module: `ook_tristate_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `word_valid` and `frame_err` are 0 and `addr_trits` and `data_bits` are all zeros.
- R2: The decoder locks only when a low width lies between 30 and 33 times (inclusive) the high width measured just before it. Every width is a count of samples from one line edge to the next. Before lock, any other pulse pair is ignored and produces neither a report nor an error.
- R3: After lock, each group of four widths decodes by its pair pattern as follows: short/long then short/long gives '0'; long/short then long/short gives '1'; short/long then long/short gives 'F'. Address position i sits at `addr_trits[2i+1:2i]` with code 00='0', 01='1', 10='F'. The first symbol received is position 0. Data bit j is 1 when the j-th data symbol is '1'.
- R4: A pair counts as short/long or long/short only when the long width is between 2 and 4 times the short width (inclusive). Any other ratio, or the order long/short then short/long, aborts the word with a one-cycle `frame_err` pulse and restarts the sync search.
- R5: An 'F' in a data position aborts the word with a one-cycle `frame_err` pulse, and no word is reported from it.
- R6: A word is reported only when it equals the word completed just before it, both being decoded without an abort in between. Two consecutive completed words that differ give a `frame_err` pulse. `word_valid` and `frame_err` are never high together.
- R7: `word_valid` is a one-cycle pulse, and the outputs `addr_trits`/`data_bits` change only with it. A repeat of the last reported word is suppressed until the line has had no edge for `IDLE_CYC` cycles.
- R8: If the width counter saturates (no edge for 2^`CNT_W`-1 cycles) while locked, the word is dropped silently, with no `frame_err`, and the sync search restarts.
- R9: After the last symbol of a word, the next high/low pair must satisfy the sync ratio of R2. Otherwise `frame_err` pulses and the word is dropped.
- R10: A burst whose first word is truncated is still decoded from its later complete repetitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled demodulated OOK data line |
| word_valid | output | 1 | One-cycle strobe: a confirmed word is on the outputs |
| addr_trits | output | 2*N_ADDR | Address positions, 2-bit code each |
| data_bits | output | N_DATA | Data bits of the confirmed word |
| frame_err | output | 1 | One-cycle pulse on a decode fault or a disagreeing repeat |

## Verification
A corrupted lock or symbol state shows within one word time, about 512 sample units. It appears either as a missing report after a burst with enough repetitions or as `frame_err` pulses on clean bursts. A wrong comparison or suppression state shows as a report count per burst other than one: no report, or a second report of the same word. A fault in the width counter shows as error pulses in idle gaps, or as a report that never arrives after the timeout gap.

// File: rtl/ook_pkg.sv
package ook_pkg;

    // classification of two consecutive level widths
    typedef enum logic [1:0] {
        PAIR_SL  = 2'd0,   // short then long
        PAIR_LS  = 2'd1,   // long then short
        PAIR_BAD = 2'd2
    } pair_e;

    // output code of one address position
    typedef enum logic [1:0] {
        TRIT_0 = 2'b00,
        TRIT_1 = 2'b01,
        TRIT_F = 2'b10
    } trit_e;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SYM    = 2'd1,
        ST_TAIL   = 2'd2
    } dec_state_e;

    localparam logic [31:0] PAIR_LO = 32'd2;
    localparam logic [31:0] PAIR_HI = 32'd4;
    localparam logic [31:0] SYNC_LO = 32'd30;
    localparam logic [31:0] SYNC_HI = 32'd33;

    // true when lw lies within [lo*sw, hi*sw]
    function automatic logic ratio_in(input logic [31:0] sw, input logic [31:0] lw,
                                      input logic [31:0] lo, input logic [31:0] hi);
        return (lw >= sw * lo) && (lw <= sw * hi);
    endfunction

endpackage

// File: rtl/ook_edge_timer.sv
module ook_edge_timer #(
    parameter int CNT_W    = 16,
    parameter int IDLE_CYC = 40000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             edge_stb,
    output logic             new_level,
    output logic [CNT_W-1:0] width,
    output logic             sat,
    output logic             idle_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] IDLE_VAL = CNT_W'(IDLE_CYC);

    logic             line_q;
    logic [CNT_W-1:0] cnt_q;

    assign edge_stb  = line_in != line_q;
    assign new_level = line_in;
    assign sat       = cnt_q == CNT_MAX;
    assign width     = sat ? CNT_MAX : cnt_q + 1'b1;
    assign idle_stb  = !edge_stb && (cnt_q == IDLE_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            cnt_q  <= CNT_MAX;
        end else begin
            line_q <= line_in;
            if (edge_stb)
                cnt_q <= '0;
            else if (!sat)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sat && !edge_stb) |=> sat);

endmodule

// File: rtl/ook_ratio_class.sv
module ook_ratio_class
    import ook_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] first_w,
    input  logic [CNT_W-1:0] second_w,
    output pair_e            cls,
    output logic             is_sync
);
    logic [31:0] a, b;
    assign a = 32'(first_w);
    assign b = 32'(second_w);

    always_comb begin
        if (ratio_in(a, b, PAIR_LO, PAIR_HI))
            cls = PAIR_SL;
        else if (ratio_in(b, a, PAIR_LO, PAIR_HI))
            cls = PAIR_LS;
        else
            cls = PAIR_BAD;
    end

    assign is_sync = ratio_in(a, b, SYNC_LO, SYNC_HI);

endmodule

// File: rtl/ook_frame_fsm.sv
module ook_frame_fsm
    import ook_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_ADDR = 8,
    parameter int N_DATA = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  edge_stb,
    input  logic                  new_level,
    input  logic [CNT_W-1:0]      width,
    input  logic                  sat,
    input  logic                  idle_stb,
    input  pair_e                 cls,
    input  logic                  is_sync,
    output logic [CNT_W-1:0]      hold_w,
    output logic                  word_valid,
    output logic [2*N_ADDR-1:0]   addr_trits,
    output logic [N_DATA-1:0]     data_bits,
    output logic                  frame_err
);
    localparam int N_SYM  = N_ADDR + N_DATA;
    localparam int SYM_W  = $clog2(N_SYM);
    localparam int WORD_W = 2 * N_ADDR + N_DATA;
    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(N_SYM - 1);

    dec_state_e        state_q;
    logic [1:0]        sub_q;
    logic [SYM_W-1:0]  idx_q;
    pair_e             first_q;
    logic [CNT_W-1:0]  hold_q;
    logic              hold_ok_q;
    logic [WORD_W-1:0] cur_q, prev_q, last_q;
    logic              have_prev_q, sup_q;
    logic              valid_q, err_q;
    logic [WORD_W-1:0] out_q;

    trit_e sym_trit;
    logic  sym_ok;

    assign hold_w = hold_q;

    // symbol from the two pair classes
    always_comb begin
        sym_ok   = 1'b1;
        sym_trit = TRIT_0;
        if (first_q == PAIR_SL && cls == PAIR_SL)
            sym_trit = TRIT_0;
        else if (first_q == PAIR_LS && cls == PAIR_LS)
            sym_trit = TRIT_1;
        else if (first_q == PAIR_SL && cls == PAIR_LS)
            sym_trit = TRIT_F;
        else
            sym_ok = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_SEARCH;
            sub_q       <= '0;
            idx_q       <= '0;
            first_q     <= PAIR_BAD;
            hold_q      <= '0;
            hold_ok_q   <= 1'b0;
            cur_q       <= '0;
            prev_q      <= '0;
            last_q      <= '0;
            have_prev_q <= 1'b0;
            sup_q       <= 1'b0;
            valid_q     <= 1'b0;
            err_q       <= 1'b0;
            out_q       <= '0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (idle_stb)
                sup_q <= 1'b0;
            if (sat && !edge_stb) begin
                state_q     <= ST_SEARCH;
                have_prev_q <= 1'b0;
                hold_ok_q   <= 1'b0;
            end else if (edge_stb) begin
                case (state_q)
                    ST_SEARCH: begin
                        if (!new_level) begin
                            hold_q    <= width;
                            hold_ok_q <= !sat;
                        end else begin
                            hold_ok_q <= 1'b0;
                            if (hold_ok_q && is_sync && !sat) begin
                                state_q <= ST_SYM;
                                sub_q   <= '0;
                                idx_q   <= '0;
                            end
                        end
                    end
                    ST_SYM: begin
                        sub_q <= sub_q + 1'b1;
                        if (sub_q == 2'd0 || sub_q == 2'd2) begin
                            hold_q <= width;
                        end else if (sub_q == 2'd1) begin
                            first_q <= cls;
                            if (cls == PAIR_BAD) begin
                                err_q       <= 1'b1;
                                state_q     <= ST_SEARCH;
                                have_prev_q <= 1'b0;
                            end
                        end else begin
                            if (!sym_ok || (idx_q >= SYM_W'(N_ADDR) && sym_trit == TRIT_F)) begin
                                err_q       <= 1'b1;
                                state_q     <= ST_SEARCH;
                                have_prev_q <= 1'b0;
                            end else begin
                                if (idx_q < SYM_W'(N_ADDR))
                                    cur_q[2*int'(idx_q) +: 2] <= sym_trit;
                                else
                                    cur_q[N_ADDR + int'(idx_q)] <= (sym_trit == TRIT_1);
                                if (idx_q == LAST_SYM)
                                    state_q <= ST_TAIL;
                                else
                                    idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (sub_q == 2'd0) begin
                            hold_q <= width;
                            sub_q  <= 2'd1;
                        end else if (is_sync) begin
                            state_q     <= ST_SYM;
                            sub_q       <= '0;
                            idx_q       <= '0;
                            prev_q      <= cur_q;
                            have_prev_q <= 1'b1;
                            if (have_prev_q && prev_q == cur_q) begin
                                if (!(sup_q && last_q == cur_q)) begin
                                    valid_q <= 1'b1;
                                    out_q   <= cur_q;
                                    last_q  <= cur_q;
                                    sup_q   <= 1'b1;
                                end
                            end else if (have_prev_q) begin
                                err_q <= 1'b1;
                            end
                        end else begin
                            err_q       <= 1'b1;
                            state_q     <= ST_SEARCH;
                            have_prev_q <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign word_valid = valid_q;
    assign frame_err  = err_q;
    assign addr_trits = out_q[2*N_ADDR-1:0];
    assign data_bits  = out_q[WORD_W-1:2*N_ADDR];

    // R2
    lock_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SYM && $past(state_q) == ST_SEARCH) |-> $past(is_sync));
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(out_q));
    // R6
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && err_q));
    // R8
    sat_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (sat && !edge_stb && state_q != ST_SEARCH) |=> (state_q == ST_SEARCH && !err_q));

endmodule

// File: rtl/ook_tristate_decoder.sv
module ook_tristate_decoder
    import ook_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int IDLE_CYC = 40000,
    parameter int N_ADDR   = 8,
    parameter int N_DATA   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_in,
    output logic                word_valid,
    output logic [2*N_ADDR-1:0] addr_trits,
    output logic [N_DATA-1:0]   data_bits,
    output logic                frame_err
);
    logic             edge_stb, new_level, sat, idle_stb, is_sync;
    logic [CNT_W-1:0] width, hold_w;
    pair_e            cls;

    ook_edge_timer #(.CNT_W(CNT_W), .IDLE_CYC(IDLE_CYC)) u_timer (
        .clk(clk), .rst(rst), .line_in(line_in),
        .edge_stb(edge_stb), .new_level(new_level), .width(width),
        .sat(sat), .idle_stb(idle_stb)
    );

    ook_ratio_class #(.CNT_W(CNT_W)) u_ratio (
        .first_w(hold_w), .second_w(width), .cls(cls), .is_sync(is_sync)
    );

    ook_frame_fsm #(.CNT_W(CNT_W), .N_ADDR(N_ADDR), .N_DATA(N_DATA)) u_fsm (
        .clk(clk), .rst(rst), .edge_stb(edge_stb), .new_level(new_level),
        .width(width), .sat(sat), .idle_stb(idle_stb), .cls(cls),
        .is_sync(is_sync), .hold_w(hold_w), .word_valid(word_valid),
        .addr_trits(addr_trits), .data_bits(data_bits), .frame_err(frame_err)
    );

endmodule

// File: tb/ook_tristate_decoder_bench.sv
module ook_tristate_decoder_bench;

    localparam int CNT_W    = 11;     // saturates after 2047 samples
    localparam int IDLE_CYC = 1000;
    localparam int N_ADDR   = 8;
    localparam int N_DATA   = 4;
    localparam int SHORT_W  = 4;
    localparam int LONG_W   = 12;
    localparam int SYNC_LW  = 124;
    localparam int GAP      = 2500;   // longer than saturation

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic word_valid, frame_err;
    logic [2*N_ADDR-1:0] addr_trits;
    logic [N_DATA-1:0]   data_bits;

    always #4 clk = ~clk;   // 125 MHz

    ook_tristate_decoder #(.CNT_W(CNT_W), .IDLE_CYC(IDLE_CYC),
                           .N_ADDR(N_ADDR), .N_DATA(N_DATA)) u_ook_tristate_decoder (
        .clk(clk), .rst(rst), .line_in(line_in), .word_valid(word_valid),
        .addr_trits(addr_trits), .data_bits(data_bits), .frame_err(frame_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int vcnt = 0;
    int ecnt = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) vcnt <= vcnt + 1;
            if (frame_err)  ecnt <= ecnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // word: 12 symbol codes, symbol i at bits [2i+1:2i]; 0='0',1='1',2='F',3=long/short then short/long
    typedef struct packed {
        logic [23:0] wa;
        logic [23:0] wb;
        logic [3:0]  reps;
        logic [3:0]  ev;
        logic [3:0]  ee;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{24'h519A24, 24'h519A24, 4'd4, 4'd1, 4'd0},   // R3 R6 basic word
        '{24'h041685, 24'h041685, 4'd4, 4'd1, 4'd0},   // R3 other word
        '{24'h519A24, 24'h519A24, 4'd3, 4'd0, 4'd0},   // R6 one decode only
        '{24'h44AA00, 24'h44AA00, 4'd6, 4'd1, 4'd0},   // R7 repeats suppressed
        '{24'h589A24, 24'h589A24, 4'd4, 4'd0, 4'd3},   // R5 F in data
        '{24'h519A24, 24'h041685, 4'd4, 4'd0, 4'd1},   // R6 disagreeing repeats
        '{24'h519A27, 24'h519A27, 4'd4, 4'd0, 4'd3},   // R4 reversed pair order
        '{24'h15AAAA, 24'h15AAAA, 4'd4, 4'd1, 4'd0}    // R3 all-F address
    };

    function automatic logic [31:0] exp_addr(input logic [23:0] w);
        logic [31:0] r = '0;
        for (int i = 0; i < N_ADDR; i++)
            r[2*i +: 2] = w[2*i +: 2];
        return r;
    endfunction

    function automatic logic [31:0] exp_data(input logic [23:0] w);
        logic [31:0] r = '0;
        for (int j = 0; j < N_DATA; j++)
            r[j] = (w[2*(N_ADDR+j) +: 2] == 2'd1);
        return r;
    endfunction

    task automatic lvl(input logic v, input int n);
        line_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_sym(input logic [1:0] c, input bit bad_ratio);
        if (bad_ratio) begin
            lvl(1, SHORT_W); lvl(0, 6*SHORT_W); lvl(1, SHORT_W); lvl(0, LONG_W);
        end else begin
            case (c)
                2'd0: begin lvl(1, SHORT_W); lvl(0, LONG_W);  lvl(1, SHORT_W); lvl(0, LONG_W);  end
                2'd1: begin lvl(1, LONG_W);  lvl(0, SHORT_W); lvl(1, LONG_W);  lvl(0, SHORT_W); end
                2'd2: begin lvl(1, SHORT_W); lvl(0, LONG_W);  lvl(1, LONG_W);  lvl(0, SHORT_W); end
                default: begin lvl(1, LONG_W); lvl(0, SHORT_W); lvl(1, SHORT_W); lvl(0, LONG_W); end
            endcase
        end
    endtask

    task automatic send_frame(input logic [23:0] w, input int first, input int bad_at);
        for (int i = first; i < 12; i++)
            send_sym(w[2*i +: 2], i == bad_at);
        lvl(1, SHORT_W);
        lvl(0, SYNC_LW);
    endtask

    task automatic send_burst(input logic [23:0] wa, input logic [23:0] wb, input int reps);
        for (int k = 1; k <= reps; k++)
            send_frame((k % 2 == 1) ? wa : wb, 0, -1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v0, e0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 valid in reset", 32'(word_valid), 32'd0);
        chk("R1 err in reset", 32'(frame_err), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 addr after reset", 32'(addr_trits), 32'd0);
        chk("R1 data after reset", 32'(data_bits), 32'd0);
        chk("R1 valid after reset", 32'(word_valid), 32'd0);
        lvl(0, GAP);

        // table walk
        for (int n = 0; n < 8; n++) begin
            v0 = vcnt; e0 = ecnt;
            send_burst(VECS[n].wa, VECS[n].wb, int'(VECS[n].reps));
            lvl(0, GAP);
            chk($sformatf("R6 R7 report count vec %0d", n), 32'(vcnt - v0), 32'(VECS[n].ev));
            chk($sformatf("R4 R5 error count vec %0d", n), 32'(ecnt - e0), 32'(VECS[n].ee));
            if (VECS[n].ev != 0) begin
                chk($sformatf("R3 addr vec %0d", n), 32'(addr_trits), exp_addr(VECS[n].wa));
                chk($sformatf("R3 data vec %0d", n), 32'(data_bits), exp_data(VECS[n].wa));
            end
        end

        // R7 short gap: still suppressed, broken tail sync flags R9
        v0 = vcnt; e0 = ecnt;
        send_burst(24'h041685, 24'h041685, 4);
        lvl(0, 500);
        send_burst(24'h041685, 24'h041685, 4);
        lvl(0, GAP);
        chk("R7 suppressed after short gap", 32'(vcnt - v0), 32'd1);
        chk("R9 bad tail sync", 32'(ecnt - e0), 32'd1);

        // R7 idle timeout re-arms the report
        v0 = vcnt; e0 = ecnt;
        send_burst(24'h44AA00, 24'h44AA00, 4);
        lvl(0, 1500);
        send_burst(24'h44AA00, 24'h44AA00, 4);
        lvl(0, GAP);
        chk("R7 report after timeout", 32'(vcnt - v0), 32'd2);
        chk("R9 tail after timeout gap", 32'(ecnt - e0), 32'd1);

        // R8 saturation while locked mid-word
        v0 = vcnt; e0 = ecnt;
        send_frame(24'h519A24, 0, -1);
        for (int i = 0; i < 5; i++) send_sym(2'd1, 1'b0);
        lvl(1, GAP);
        lvl(0, GAP);
        chk("R8 silent abort", 32'(ecnt - e0), 32'd0);
        send_burst(24'h519A24, 24'h519A24, 4);
        lvl(0, GAP);
        chk("R8 relock after abort", 32'(vcnt - v0), 32'd1);
        chk("R8 no error after relock", 32'(ecnt - e0), 32'd0);

        // R10 truncated first word
        v0 = vcnt; e0 = ecnt;
        send_frame(24'h15AAAA, 7, -1);
        send_burst(24'h041685, 24'h041685, 3);
        lvl(0, GAP);
        chk("R10 truncated burst report", 32'(vcnt - v0), 32'd1);
        chk("R10 truncated burst addr", 32'(addr_trits), exp_addr(24'h041685));
        chk("R10 truncated burst errors", 32'(ecnt - e0), 32'd0);

        // R4 pair ratio of 6 rejected
        v0 = vcnt; e0 = ecnt;
        for (int k = 0; k < 4; k++) send_frame(24'h519A24, 0, 3);
        lvl(0, GAP);
        chk("R4 bad ratio errors", 32'(ecnt - e0), 32'd3);
        chk("R4 bad ratio no report", 32'(vcnt - v0), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule